// File: doc/BRIEF.md
# Wishbone Pipelined Width Upsizer (32 to 128 bit)

This bridge lets a master with a 32-bit pipelined Wishbone port reach a slave that has a 128-bit pipelined Wishbone port. Each narrow request goes out as exactly one wide request. The wide word address is the narrow word address with its two lowest bits removed. On writes, the narrow data appears in every 32-bit lane of the wide bus. The byte enables are moved into the lane that the two dropped address bits select.

The two dropped bits of every request that the wide slave accepts are kept in a 16-entry queue. When the wide slave acknowledges, the oldest queued lane index picks the 32-bit slice of the wide read data. That slice and the narrow acknowledge appear together one clock later. When 16 requests are outstanding, the narrow side is stalled and the wide strobe is held low, so the queue cannot overrun. A wide stall records nothing, so a request that waits through several stall cycles is queued only once.

If the wide slave signals an error, or the master drops its cycle, the outstanding entries are discarded. An error is reported upstream one clock later.

Top module: `wb_upsizer`

## Requirements
- R1: An accepted request drives `w_adr_o` with `n_adr_i[29:2]`.
- R2: For a write, each of the four 32-bit lanes of `w_dat_o` carries `n_dat_i`.
- R3: The lane index is `n_adr_i[1:0]`. Lane k occupies data bits [32k+31:32k] and enable bits [4k+3:4k]. `w_sel_o` holds `n_sel_i` in the addressed lane and zeros in the other three lanes.
- R4: In the clock after `w_ack_i`, `n_ack_o` is high. `n_dat_o` is then the lane of `w_dat_i` named by the oldest outstanding request, so responses follow request order.
- R5: At most 16 requests are outstanding. While 16 are outstanding, `n_stall_o` is high and `w_stb_o` is low.
- R6: A wide stall raises `n_stall_o`. A stalled cycle records no lane, so lane order stays correct under any stall pattern.
- R7: `w_err_i` during a cycle gives a one-clock `n_err_o` in the following clock and discards all outstanding lane entries.
- R8: Dropping `n_cyc_i` discards all outstanding entries. A `w_ack_i` with nothing outstanding produces no `n_ack_o`.
- R9: During reset, `n_ack_o` and `n_err_o` are low. With no wide stall and nothing outstanding, `n_stall_o` is low.
- R10: `w_cyc_o` follows `n_cyc_i` and `w_we_o` follows `n_we_i`. No strobe reaches the wide side while `n_cyc_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| n_cyc_i | input | 1 | Narrow cycle |
| n_stb_i | input | 1 | Narrow strobe |
| n_we_i | input | 1 | Narrow write enable |
| n_adr_i | input | 30 | Narrow word address |
| n_dat_i | input | 32 | Narrow write data |
| n_sel_i | input | 4 | Narrow byte enables |
| n_stall_o | output | 1 | Narrow stall |
| n_ack_o | output | 1 | Narrow acknowledge |
| n_err_o | output | 1 | Narrow error |
| n_dat_o | output | 32 | Narrow read data |
| w_cyc_o | output | 1 | Wide cycle |
| w_stb_o | output | 1 | Wide strobe |
| w_we_o | output | 1 | Wide write enable |
| w_adr_o | output | 28 | Wide word address |
| w_dat_o | output | 128 | Wide write data |
| w_sel_o | output | 16 | Wide byte enables |
| w_stall_i | input | 1 | Wide stall |
| w_ack_i | input | 1 | Wide acknowledge |
| w_err_i | input | 1 | Wide error |
| w_dat_i | input | 128 | Wide read data |

## Verification
Some properties are checked on every clock:
- the queue never exceeds 16 entries, and a full queue stalls the master and blocks the strobe;
- a stalled cycle leaves the occupancy unchanged;
- an acknowledge with something outstanding produces a narrow acknowledge one clock later, and one with nothing outstanding produces none;
- an error or a dropped cycle empties the queue.

Only the bench scenarios can show that the returned slices come from the right lanes in the right order. They do this with a scoreboard against a modelled wide memory, using random stalls and held-off acknowledges. The scenarios also show that the write data and byte-enable placement are correct. Finally, they show that reads issued after an error or a dropped cycle see no stale lane entries.

// File: rtl/wbup_pkg.sv
package wbup_pkg;
  typedef enum logic [1:0] {
    RSP_IDLE = 2'd0,
    RSP_ACK  = 2'd1,
    RSP_ERR  = 2'd2
  } rsp_kind_e;
endpackage

// File: rtl/wbup_req_map.sv
module wbup_req_map #(
  parameter int AW = 30,
  parameter int NARROW_DW = 32,
  parameter int WIDE_DW = 128,
  localparam int RATIO = WIDE_DW / NARROW_DW,
  localparam int LW = $clog2(RATIO),
  localparam int NB = NARROW_DW / 8,
  localparam int WB = WIDE_DW / 8,
  localparam int WAW = AW - LW
) (
  input  logic [AW-1:0]        adr_i,
  input  logic [NARROW_DW-1:0] dat_i,
  input  logic [NB-1:0]        sel_i,
  output logic [WAW-1:0]       adr_o,
  output logic [WIDE_DW-1:0]   dat_o,
  output logic [WB-1:0]        sel_o,
  output logic [LW-1:0]        lane_o
);
  assign lane_o = adr_i[LW-1:0];
  assign adr_o  = adr_i[AW-1:LW];

  for (genvar k = 0; k < RATIO; k++) begin : g_lane
    assign dat_o[k*NARROW_DW +: NARROW_DW] = dat_i;
    assign sel_o[k*NB +: NB] = (lane_o == LW'(k)) ? sel_i : '0;
  end
endmodule

// File: rtl/wbup_lane_fifo.sv
module wbup_lane_fifo #(
  parameter int W = 2,
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  din_i,
  output logic [W-1:0]  head_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [CW-1:0] occ_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] occ_q;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full_o  = (occ_q == CW'(DEPTH));
  assign empty_o = (occ_q == '0);
  assign occ_o   = occ_q;
  assign head_o  = mem_q[rd_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      occ_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      occ_q <= '0;
    end else begin
      if (do_push) wr_q <= bump(wr_q);
      if (do_pop)  rd_q <= bump(rd_q);
      case ({do_push, do_pop})
        2'b10:   occ_q <= occ_q + CW'(1);
        2'b01:   occ_q <= occ_q - CW'(1);
        default: occ_q <= occ_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_q] <= din_i;
  end
endmodule

// File: rtl/wbup_rsp_sel.sv
module wbup_rsp_sel
  import wbup_pkg::*;
#(
  parameter int NARROW_DW = 32,
  parameter int WIDE_DW = 128,
  localparam int LW = $clog2(WIDE_DW / NARROW_DW)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cyc_i,
  input  logic                 ack_i,
  input  logic                 err_i,
  input  logic                 pending_i,
  input  logic [LW-1:0]        lane_i,
  input  logic [WIDE_DW-1:0]   dat_i,
  output logic                 ack_o,
  output logic                 err_o,
  output logic [NARROW_DW-1:0] dat_o
);
  rsp_kind_e kind_d, kind_q;
  logic [NARROW_DW-1:0] dat_q;

  always_comb begin
    kind_d = RSP_IDLE;
    if (cyc_i && err_i)                   kind_d = RSP_ERR;
    else if (cyc_i && ack_i && pending_i) kind_d = RSP_ACK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= RSP_IDLE;
      dat_q  <= '0;
    end else begin
      kind_q <= kind_d;
      if (kind_d == RSP_ACK) dat_q <= dat_i[lane_i*NARROW_DW +: NARROW_DW];
    end
  end

  assign ack_o = (kind_q == RSP_ACK);
  assign err_o = (kind_q == RSP_ERR);
  assign dat_o = dat_q;
endmodule

// File: rtl/wb_upsizer.sv
module wb_upsizer #(
  parameter int AW = 30,
  parameter int NARROW_DW = 32,
  parameter int WIDE_DW = 128,
  parameter int DEPTH = 16,
  localparam int LW = $clog2(WIDE_DW / NARROW_DW),
  localparam int NB = NARROW_DW / 8,
  localparam int WB = WIDE_DW / 8,
  localparam int WAW = AW - LW,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 n_cyc_i,
  input  logic                 n_stb_i,
  input  logic                 n_we_i,
  input  logic [AW-1:0]        n_adr_i,
  input  logic [NARROW_DW-1:0] n_dat_i,
  input  logic [NB-1:0]        n_sel_i,
  output logic                 n_stall_o,
  output logic                 n_ack_o,
  output logic                 n_err_o,
  output logic [NARROW_DW-1:0] n_dat_o,
  output logic                 w_cyc_o,
  output logic                 w_stb_o,
  output logic                 w_we_o,
  output logic [WAW-1:0]       w_adr_o,
  output logic [WIDE_DW-1:0]   w_dat_o,
  output logic [WB-1:0]        w_sel_o,
  input  logic                 w_stall_i,
  input  logic                 w_ack_i,
  input  logic                 w_err_i,
  input  logic [WIDE_DW-1:0]   w_dat_i
);
  logic [LW-1:0] req_lane, head_lane;
  logic          fifo_full, fifo_empty, flush, accept;
  logic [CW-1:0] occ;

  wbup_req_map #(.AW(AW), .NARROW_DW(NARROW_DW), .WIDE_DW(WIDE_DW)) u_map (
    .adr_i  (n_adr_i),
    .dat_i  (n_dat_i),
    .sel_i  (n_sel_i),
    .adr_o  (w_adr_o),
    .dat_o  (w_dat_o),
    .sel_o  (w_sel_o),
    .lane_o (req_lane)
  );

  // Throttle on the registered count only; keeps w_ack_i off the stall path.
  assign w_cyc_o   = n_cyc_i;
  assign w_we_o    = n_we_i;
  assign w_stb_o   = n_cyc_i && n_stb_i && !fifo_full && !w_err_i;
  assign n_stall_o = fifo_full || w_stall_i;
  assign accept    = w_stb_o && !w_stall_i;
  assign flush     = !n_cyc_i || w_err_i;

  wbup_lane_fifo #(.W(LW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (accept),
    .pop_i   (w_ack_i),
    .din_i   (req_lane),
    .head_o  (head_lane),
    .full_o  (fifo_full),
    .empty_o (fifo_empty),
    .occ_o   (occ)
  );

  wbup_rsp_sel #(.NARROW_DW(NARROW_DW), .WIDE_DW(WIDE_DW)) u_rsp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cyc_i     (n_cyc_i),
    .ack_i     (w_ack_i),
    .err_i     (w_err_i),
    .pending_i (!fifo_empty),
    .lane_i    (head_lane),
    .dat_i     (w_dat_i),
    .ack_o     (n_ack_o),
    .err_o     (n_err_o),
    .dat_o     (n_dat_o)
  );
endmodule

// File: rtl/wb_upsizer_chk.sv
module wb_upsizer_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          n_cyc_i,
  input logic          n_stall_o,
  input logic          n_ack_o,
  input logic          n_err_o,
  input logic          w_cyc_o,
  input logic          w_stb_o,
  input logic          w_stall_i,
  input logic          w_ack_i,
  input logic          w_err_i,
  input logic [CW-1:0] occ_i
);
  p_ack_lat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_cyc_i && w_ack_i && !w_err_i && occ_i != '0) |=> n_ack_o);

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_i <= CW'(DEPTH));

  p_full_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_i == CW'(DEPTH)) |-> (n_stall_o && !w_stb_o));

  p_stall_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_cyc_i && w_stall_i && !w_ack_i && !w_err_i) |=> (occ_i == $past(occ_i)));

  p_stall_up_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_stall_i |-> n_stall_o);

  p_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_cyc_i && w_err_i) |=> (n_err_o && occ_i == '0));

  p_flush_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !n_cyc_i |=> (occ_i == '0));

  p_no_spur_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!w_ack_i || !n_cyc_i || occ_i == '0) |=> !n_ack_o);

  p_no_cyc_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !n_cyc_i |-> (!w_stb_o && !w_cyc_o));
endmodule

bind wb_upsizer wb_upsizer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .n_cyc_i   (n_cyc_i),
  .n_stall_o (n_stall_o),
  .n_ack_o   (n_ack_o),
  .n_err_o   (n_err_o),
  .w_cyc_o   (w_cyc_o),
  .w_stb_o   (w_stb_o),
  .w_stall_i (w_stall_i),
  .w_ack_i   (w_ack_i),
  .w_err_i   (w_err_i),
  .occ_i     (occ)
);

// File: tb/wb_upsizer_test.sv
`timescale 1ns/1ps
module wb_upsizer_test;
  localparam int AW = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic n_cyc = 0, n_stb = 0, n_we = 0;
  logic [AW-1:0] n_adr = '0;
  logic [31:0] n_dat = '0;
  logic [3:0] n_sel = '0;
  logic n_stall_o, n_ack_o, n_err_o;
  logic [31:0] n_dat_o;
  logic w_cyc_o, w_stb_o, w_we_o;
  logic [AW-3:0] w_adr_o;
  logic [127:0] w_dat_o;
  logic [15:0] w_sel_o;
  logic w_stall_i = 0, w_ack_i = 0, w_err_i = 0;
  logic [127:0] w_dat_i = '0;

  wb_upsizer uut (
    .clk_i(clk), .rst_ni(rst_n),
    .n_cyc_i(n_cyc), .n_stb_i(n_stb), .n_we_i(n_we), .n_adr_i(n_adr),
    .n_dat_i(n_dat), .n_sel_i(n_sel), .n_stall_o(n_stall_o), .n_ack_o(n_ack_o),
    .n_err_o(n_err_o), .n_dat_o(n_dat_o),
    .w_cyc_o(w_cyc_o), .w_stb_o(w_stb_o), .w_we_o(w_we_o), .w_adr_o(w_adr_o),
    .w_dat_o(w_dat_o), .w_sel_o(w_sel_o), .w_stall_i(w_stall_i), .w_ack_i(w_ack_i),
    .w_err_i(w_err_i), .w_dat_i(w_dat_i)
  );

  int checks = 0, fails = 0, err_seen = 0, ack_seen = 0;
  bit ack_hold = 0, stall_rand = 0, err_inject = 0, spur_inject = 0, done = 0;
  logic [15:0] lfsr = 16'hACE1;

  typedef struct { logic we; logic [AW-1:0] adr; logic [31:0] dat; logic [3:0] sel; } req_t;
  typedef struct { logic we; logic [31:0] dat; } rsp_t;
  req_t req_q[$];
  rsp_t rsp_q[$];
  logic [AW-3:0] pend_q[$];

  function automatic logic [31:0] mem_word(logic [AW-3:0] wa, logic [1:0] lane);
    return {lane, wa[13:0], 16'h0} ^ {4'h0, wa} ^ 32'hC3A5_0F1E;
  endfunction

  function automatic logic [127:0] mem_line(logic [AW-3:0] wa);
    logic [127:0] l;
    for (int k = 0; k < 4; k++) l[32*k +: 32] = mem_word(wa, 2'(k));
    return l;
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Wide-side acceptance monitor: request mapping checks (R1 R2 R3 R10)
  always @(posedge clk) begin
    if (rst_n && !w_cyc_o) pend_q.delete();
    if (rst_n && w_cyc_o && w_stb_o && !w_stall_i) begin
      if (req_q.size() == 0) chk(0, "R5 unexpected wide request", 1, 0);
      else begin
        req_t r;
        r = req_q.pop_front();
        chk(w_adr_o == r.adr[AW-1:2], "R1 wide address", 128'(w_adr_o), 128'(r.adr[AW-1:2]));
        chk(w_we_o == r.we, "R10 write enable", 128'(w_we_o), 128'(r.we));
        if (r.we) begin
          chk(w_dat_o == {4{r.dat}}, "R2 write data lanes", w_dat_o, {4{r.dat}});
          chk(w_sel_o == (16'(r.sel) << (4 * int'(r.adr[1:0]))), "R3 byte enables",
              128'(w_sel_o), 128'(16'(r.sel) << (4 * int'(r.adr[1:0]))));
        end
        pend_q.push_back(w_adr_o);
      end
    end
  end

  // Wide slave model
  always @(negedge clk) begin
    w_ack_i = 0;
    w_err_i = 0;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    w_stall_i = stall_rand && lfsr[0];
    if (err_inject) begin
      w_err_i = 1;
      pend_q.delete();
      err_inject = 0;
    end else if (spur_inject) begin
      w_ack_i = 1;
      w_dat_i = '1;
      spur_inject = 0;
    end else if (!ack_hold && pend_q.size() > 0 && !(stall_rand && lfsr[3])) begin
      w_ack_i = 1;
      w_dat_i = mem_line(pend_q.pop_front());
    end
  end

  // Narrow-side response monitor (R4 R8)
  always @(negedge clk) begin
    if (rst_n) begin
      if (n_err_o) err_seen++;
      if (n_ack_o) begin
        ack_seen++;
        if (rsp_q.size() == 0) chk(0, "R8 ack with nothing outstanding", 1, 0);
        else begin
          rsp_t r;
          r = rsp_q.pop_front();
          if (!r.we) chk(n_dat_o == r.dat, "R4 read lane data", 128'(n_dat_o), 128'(r.dat));
        end
      end
    end
  end

  task automatic issue(bit we, logic [AW-1:0] adr, logic [31:0] dat, logic [3:0] sel, bit last);
    @(negedge clk);
    n_cyc = 1; n_stb = 1; n_we = we; n_adr = adr; n_dat = dat; n_sel = sel;
    #1;
    while (n_stall_o) begin
      @(negedge clk);
      #1;
    end
    req_q.push_back('{we, adr, dat, sel});
    rsp_q.push_back('{we, we ? 32'h0 : mem_word(adr[AW-1:2], adr[1:0])});
    @(posedge clk);
    if (last) begin
      @(negedge clk);
      n_stb = 0;
    end
  endtask

  task automatic drain(string req);
    for (int i = 0; i < 3000 && rsp_q.size() != 0; i++) @(posedge clk);
    repeat (2) @(posedge clk);
    chk(rsp_q.size() == 0, req, 128'(rsp_q.size()), 0);
  endtask

  task automatic drop_cycle();
    @(negedge clk);
    n_cyc = 0; n_stb = 0;
    rsp_q.delete();
    req_q.delete();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    chk(!n_ack_o && !n_err_o, "R9 reset ack/err", 128'({n_ack_o, n_err_o}), 0);
    chk(!n_stall_o, "R9 reset stall", 128'(n_stall_o), 0);
    chk(!w_stb_o && !w_cyc_o, "R10 idle wide side", 128'({w_stb_o, w_cyc_o}), 0);
    @(posedge clk);
    rst_n = 1;

    // R10 cycle follows
    @(negedge clk);
    n_cyc = 1;
    #1 chk(w_cyc_o, "R10 cycle follows", 128'(w_cyc_o), 1);

    // R2 R3 writes to every lane, then R4 reads of every lane
    for (int k = 0; k < 4; k++)
      issue(1, AW'(32'h100 + k), 32'hDEAD_0000 + 32'(k), 4'(1 << k) | 4'h1, 0);
    issue(1, AW'(32'h205), 32'h1234_5678, 4'hF, 1);
    drain("R4 write acks returned");
    for (int k = 0; k < 8; k++) issue(0, AW'(32'h340 + (k * 5)), '0, 4'hF, k == 7);
    drain("R4 reads returned");

    // R6 random downstream stalls and ack gaps, mixed traffic
    stall_rand = 1;
    for (int k = 0; k < 48; k++)
      issue((k % 5) == 3, AW'(32'h1000 + (k * 7)), 32'hA5A5_0000 ^ 32'(k), 4'(k), k == 47);
    drain("R6 ordered under stalls");
    @(negedge clk);
    w_stall_i = 1;
    #0.5 chk(n_stall_o, "R6 stall passes up", 128'(n_stall_o), 1);
    @(posedge clk);
    stall_rand = 0;

    // R5 fill to 16 outstanding
    ack_hold = 1;
    for (int k = 0; k < 16; k++) issue(0, AW'(32'h2000 + (k * 3)), '0, 4'hF, k == 15);
    @(negedge clk);
    #1.5 chk(n_stall_o, "R5 stall at 16 outstanding", 128'(n_stall_o), 1);
    fork
      issue(0, AW'(32'h2102), '0, 4'hF, 1);
      begin
        @(negedge clk);
        #1.5 chk(!w_stb_o && n_stall_o, "R5 strobe blocked when full",
                 128'({w_stb_o, n_stall_o}), 128'(2'b01));
        @(posedge clk);
        ack_hold = 0;
      end
    join
    drain("R5 all 17 returned");

    // R7 error flushes and reports
    ack_hold = 1;
    for (int k = 0; k < 3; k++) issue(0, AW'(32'h3003 + k), '0, 4'hF, k == 2);
    begin
      int e0;
      e0 = err_seen;
      @(posedge clk);
      err_inject = 1;
      @(posedge clk);
      #1 chk(n_err_o, "R7 error one clock later", 128'(n_err_o), 1);
      repeat (3) @(posedge clk);
      chk(err_seen == e0 + 1, "R7 single error pulse", 128'(err_seen - e0), 1);
    end
    drop_cycle();
    ack_hold = 0;
    @(negedge clk);
    n_cyc = 1;
    issue(0, AW'(32'h3102), '0, 4'hF, 0);
    issue(0, AW'(32'h3201), '0, 4'hF, 1);
    drain("R7 fresh reads after error");

    // R8 cycle drop flushes, spurious ack ignored
    ack_hold = 1;
    for (int k = 0; k < 4; k++) issue(0, AW'(32'h4003 + (k * 4)), '0, 4'hF, k == 3);
    drop_cycle();
    ack_hold = 0;
    @(negedge clk);
    n_cyc = 1;
    begin
      int a0;
      a0 = ack_seen;
      @(posedge clk);
      spur_inject = 1;
      repeat (4) @(posedge clk);
      chk(ack_seen == a0, "R8 spurious ack ignored", 128'(ack_seen - a0), 0);
    end
    issue(0, AW'(32'h4101), '0, 4'hF, 0);
    issue(0, AW'(32'h4200), '0, 4'hF, 1);
    drain("R8 fresh reads after drop");

    drop_cycle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule